// File: doc/BRIEF.md
# Tone-Bus Reply Receiver with Word FIFO

This block listens for reply messages on a 22 kHz tone-burst control line of the kind used between a satellite receiver and its dish electronics. An external detector turns the tone into a clean, synchronous envelope bit (`tone_in`, 1 while tone is present). When the local transmitter reports the end of its own message on `tx_done`, the receiver waits a fixed arming delay and then starts listening. If no tone appears within a programmable number of cycles, it flags that no reply came. Otherwise it measures how long the tone stays on in each bit slot and turns that into a bit. Nine bits make one word: eight data bits followed by an odd-parity bit.

Each complete word goes into a small FIFO together with its received parity bit and a parity-error flag. A status byte reports the following:
- bit 0: at least one word has arrived;
- bit 1: the message has ended;
- bit 2: a word was dropped because the FIFO was full;
- bit 3: no reply came;
- bits 7:4: the number of words held.

The host reads each word in two accesses to the FIFO address. The first access returns the data byte. The second returns the parity information and removes the word. An interrupt output, gated by an enable input, tells the host that something happened.

The decoder is a five-state machine. The states are:
- `ST_IDLE`: not listening.
- `ST_ARM`: counting the arming delay.
- `ST_LISTEN`: waiting for the first tone, with the reply timeout running.
- `ST_MARK`: measuring how long the tone stays on.
- `ST_SPACE`: measuring the silence after a tone.

The transitions are:
- From any state, `tx_done` leads to `ST_ARM`.
- `ST_ARM` moves to `ST_LISTEN` when the delay has elapsed.
- `ST_LISTEN` moves to `ST_MARK` when tone is seen, or to `ST_IDLE` on timeout.
- `ST_MARK` moves to `ST_SPACE` when the tone falls. This emits one bit.
- `ST_SPACE` moves to `ST_MARK` when the tone rises again, or to `ST_IDLE` when the silence reaches one bit period. This marks the end of the message.

Top module: `tone_reply_rx`

## Requirements
- R1: After a `tx_done` pulse, tone on `tone_in` is ignored for ARM_DLY_CYC cycles. Listening starts after that delay. The same pulse clears status bits 0, 1 and 3.
- R2: A bit slot begins at a rising edge of `tone_in`. Tone held for fewer than BIT_CYC/2 cycles decodes as 1. Tone held for BIT_CYC/2 cycles or more decodes as 0.
- R3: A word is nine bits: eight data bits, most significant first, then a parity bit. The parity-error flag is set when the nine bits hold an even number of ones (odd parity expected).
- R4: Silence of BIT_CYC cycles after a tone sets status bit 1 (message complete). A word left unfinished at that point is discarded.
- R5: If no tone is seen within `reply_timeout` cycles after listening starts, status bit 3 (no reply) is set and status bit 1 stays 0.
- R6: Status bit 0 is set when a word arrives.
- R7: Status bits 7:4 give the number of words held. This count drops by one after each completed two-access read.
- R8: A read with `rd_addr`=1 returns the data byte on the first access. The second access returns {6'b0, parity-error at bit 1, received parity at bit 0} and removes the word. A read of an empty FIFO returns 0 and does not advance the access phase. `rd_data` is valid in the cycle after `rd_en`.
- R9: A word that arrives while DEPTH words are held is dropped and sets status bit 2. The held words are unchanged. A status read (`rd_addr`=0) clears bit 2.
- R10: `irq` equals `irq_en` AND a pending flag. The pending flag is set by a word arrival, a message end or a no-reply event, and is cleared by a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_in | input | 1 | Synchronous tone envelope, 1 while tone present |
| tx_done | input | 1 | One-cycle pulse at the end of a local transmission |
| irq_en | input | 1 | Interrupt enable |
| reply_timeout | input | TMO_W | No-reply timeout in clock cycles |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0 = status byte, 1 = FIFO word |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `tone_in` is already synchronous to `clk` and free of glitches.
- `tx_done` is a single-cycle pulse.
- `reply_timeout` does not change while listening.
- `rd_en` is the only way the host touches the FIFO.

The stimulus respects these assumptions. It drives every input one nanosecond after a rising edge. It shapes each bit as exactly one third or two thirds of a 24-cycle slot, and it issues reads as single-cycle strobes. The gap after each message is three bit periods long, so the end of the message is always detected before the status is sampled.

// File: rtl/tonerx_pkg.sv
package tonerx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_LISTEN,
        ST_MARK,
        ST_SPACE
    } rx_state_e;

    typedef struct packed {
        logic       perr;
        logic       par;
        logic [7:0] data;
    } rx_word_t;

    localparam int WORD_BITS = 9;

endpackage

// File: rtl/tonerx_bitdec.sv
module tonerx_bitdec
    import tonerx_pkg::*;
#(
    parameter int BIT_CYC     = 187500,
    parameter int ARM_DLY_CYC = 625000,
    parameter int TMO_W       = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_in,
    input  logic             tx_done,
    input  logic [TMO_W-1:0] reply_timeout,
    output logic             bit_stb,
    output logic             bit_val,
    output logic             msg_end,
    output logic             no_reply
);
    localparam int AW    = $clog2(ARM_DLY_CYC + 1);
    localparam int BW    = $clog2(BIT_CYC + 1);
    localparam int ABW   = (AW > BW) ? AW : BW;
    localparam int CNT_W = (ABW > TMO_W) ? ABW : TMO_W;
    localparam int HALF  = BIT_CYC / 2;

    rx_state_e        state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             arm_over, gap_over, tmo_over;

    assign arm_over = (cnt >= CNT_W'(ARM_DLY_CYC - 1));
    assign gap_over = (cnt >= CNT_W'(BIT_CYC - 1));
    assign tmo_over = (cnt >= CNT_W'(reply_timeout));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Next state
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (tx_done) begin
            nxt     = ST_ARM;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt_nxt = '0;
                end
                ST_ARM: begin
                    if (arm_over) begin
                        nxt     = ST_LISTEN;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + CNT_W'(1);
                    end
                end
                ST_LISTEN: begin
                    if (tone_in) begin
                        nxt     = ST_MARK;
                        cnt_nxt = CNT_W'(1);
                    end else if (tmo_over) begin
                        nxt     = ST_IDLE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + CNT_W'(1);
                    end
                end
                ST_MARK: begin
                    if (!tone_in) begin
                        nxt     = ST_SPACE;
                        cnt_nxt = CNT_W'(1);
                    end else if (cnt < CNT_W'(BIT_CYC)) begin
                        cnt_nxt = cnt + CNT_W'(1);
                    end
                end
                ST_SPACE: begin
                    if (tone_in) begin
                        nxt     = ST_MARK;
                        cnt_nxt = CNT_W'(1);
                    end else if (gap_over) begin
                        nxt     = ST_IDLE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + CNT_W'(1);
                    end
                end
                default: begin
                    nxt     = ST_IDLE;
                    cnt_nxt = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        bit_stb  = !tx_done && (state == ST_MARK) && !tone_in;
        bit_val  = (cnt < CNT_W'(HALF));
        msg_end  = !tx_done && (state == ST_SPACE) && !tone_in && gap_over;
        no_reply = !tx_done && (state == ST_LISTEN) && !tone_in && tmo_over;
    end

endmodule

// File: rtl/tonerx_assemble.sv
module tonerx_assemble
    import tonerx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     bit_stb,
    input  logic     bit_val,
    output logic     word_stb,
    output rx_word_t word
);
    localparam int BC_W = $clog2(WORD_BITS + 1);

    logic [7:0]      sr;
    logic [BC_W-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            bcnt     <= '0;
            word_stb <= 1'b0;
            word     <= '0;
        end else begin
            word_stb <= 1'b0;
            if (clr) begin
                bcnt <= '0;
            end else if (bit_stb) begin
                if (bcnt == BC_W'(WORD_BITS - 1)) begin
                    word_stb  <= 1'b1;
                    word.data <= sr;
                    word.par  <= bit_val;
                    word.perr <= ~(^sr ^ bit_val);
                    bcnt      <= '0;
                end else begin
                    sr   <= {sr[6:0], bit_val};
                    bcnt <= bcnt + BC_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tonerx_fifo.sv
module tonerx_fifo #(
    parameter int  W     = 10,
    parameter int  DEPTH = 8,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wptr <= bump(wptr);
            end
            if (pop) begin
                rptr <= bump(rptr);
            end
            if (push && !pop) begin
                count <= count + CW'(1);
            end else if (pop && !push) begin
                count <= count - CW'(1);
            end
        end
    end

    assign dout  = mem[rptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

endmodule

// File: rtl/tone_reply_rx.sv
module tone_reply_rx
    import tonerx_pkg::*;
#(
    parameter int BIT_CYC     = 187500,
    parameter int ARM_DLY_CYC = 625000,
    parameter int DEPTH       = 8,
    parameter int TMO_W       = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_in,
    input  logic             tx_done,
    input  logic             irq_en,
    input  logic [TMO_W-1:0] reply_timeout,
    input  logic             rd_en,
    input  logic             rd_addr,
    output logic [7:0]       rd_data,
    output logic             irq
);
    localparam int FCW = $clog2(DEPTH + 1);
    localparam int WW  = $bits(rx_word_t);

    logic           bit_stb, bit_val, msg_end, no_reply;
    logic           word_stb;
    rx_word_t       word, head;
    logic [WW-1:0]  head_bits;
    logic [FCW-1:0] fifo_count;
    logic           fifo_full, fifo_empty;
    logic           push, pop, rd_stat, rd_fifo;
    logic           st_rcvd, st_done, st_ovf, st_noreply, pend, rd_phase;
    logic [7:0]     stat_word;

    tonerx_bitdec #(
        .BIT_CYC    (BIT_CYC),
        .ARM_DLY_CYC(ARM_DLY_CYC),
        .TMO_W      (TMO_W)
    ) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .tone_in      (tone_in),
        .tx_done      (tx_done),
        .reply_timeout(reply_timeout),
        .bit_stb      (bit_stb),
        .bit_val      (bit_val),
        .msg_end      (msg_end),
        .no_reply     (no_reply)
    );

    tonerx_assemble u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_done | msg_end),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .word_stb(word_stb),
        .word    (word)
    );

    tonerx_fifo #(
        .W    (WW),
        .DEPTH(DEPTH)
    ) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .din  (word),
        .pop  (pop),
        .dout (head_bits),
        .count(fifo_count),
        .full (fifo_full),
        .empty(fifo_empty)
    );

    assign head      = rx_word_t'(head_bits);
    assign rd_stat   = rd_en && !rd_addr;
    assign rd_fifo   = rd_en && rd_addr;
    assign push      = word_stb && !fifo_full;
    assign pop       = rd_fifo && rd_phase && !fifo_empty;
    assign stat_word = {4'(fifo_count), st_noreply, st_ovf, st_done, st_rcvd};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_rcvd    <= 1'b0;
            st_done    <= 1'b0;
            st_noreply <= 1'b0;
        end else if (tx_done) begin
            st_rcvd    <= 1'b0;
            st_done    <= 1'b0;
            st_noreply <= 1'b0;
        end else begin
            if (word_stb) st_rcvd    <= 1'b1;
            if (msg_end)  st_done    <= 1'b1;
            if (no_reply) st_noreply <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_ovf <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (word_stb && fifo_full) begin
                st_ovf <= 1'b1;
            end else if (rd_stat) begin
                st_ovf <= 1'b0;
            end
            if (word_stb || msg_end || no_reply) begin
                pend <= 1'b1;
            end else if (rd_stat) begin
                pend <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_phase <= 1'b0;
        end else if (rd_stat) begin
            rd_data <= stat_word;
        end else if (rd_fifo) begin
            if (fifo_empty) begin
                rd_data <= '0;
            end else if (!rd_phase) begin
                rd_data  <= head.data;
                rd_phase <= 1'b1;
            end else begin
                rd_data  <= {6'b0, head.perr, head.par};
                rd_phase <= 1'b0;
            end
        end
    end

    assign irq = irq_en && pend;

endmodule

// File: rtl/tonerx_chk.sv
module tonerx_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_done,
    input logic          irq_en,
    input logic          irq,
    input logic          bit_stb,
    input logic          word_stb,
    input logic          fifo_full,
    input logic [CW-1:0] fifo_count,
    input logic          push,
    input logic          pop,
    input logic          st_rcvd,
    input logic          st_done,
    input logic          st_ovf,
    input logic          st_noreply
);
    assert_arm_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !bit_stb);

    assert_no_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_done && st_noreply));

    assert_rcvd_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> st_rcvd);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    assert_pop_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (fifo_count == $past(fifo_count) - CW'(1)));

    assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && fifo_full) |=> st_ovf);

    assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && fifo_full && !pop) |=> (fifo_count == $past(fifo_count)));

    assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> (irq || !irq_en));

endmodule

bind tone_reply_rx tonerx_chk #(
    .DEPTH(DEPTH),
    .CW   (FCW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_done   (tx_done),
    .irq_en    (irq_en),
    .irq       (irq),
    .bit_stb   (bit_stb),
    .word_stb  (word_stb),
    .fifo_full (fifo_full),
    .fifo_count(fifo_count),
    .push      (push),
    .pop       (pop),
    .st_rcvd   (st_rcvd),
    .st_done   (st_done),
    .st_ovf    (st_ovf),
    .st_noreply(st_noreply)
);

// File: tb/tb_tone_reply_rx.sv
`timescale 1ns/1ps
module tb_tone_reply_rx;
    localparam int BITC  = 24;
    localparam int ARMC  = 40;
    localparam int DEP   = 8;
    localparam int TW    = 16;
    localparam int TMO   = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tone_in = 1'b0;
    logic          tx_done = 1'b0;
    logic          irq_en = 1'b0;
    logic [TW-1:0] reply_timeout = TW'(TMO);
    logic          rd_en = 1'b0;
    logic          rd_addr = 1'b0;
    logic [7:0]    rd_data;
    logic          irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tone_reply_rx #(
        .BIT_CYC    (BITC),
        .ARM_DLY_CYC(ARMC),
        .DEPTH      (DEP),
        .TMO_W      (TW)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tone_in      (tone_in),
        .tx_done      (tx_done),
        .irq_en       (irq_en),
        .reply_timeout(reply_timeout),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .irq          (irq)
    );

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic arm();
        tx_done = 1'b1;
        cyc(1);
        tx_done = 1'b0;
        cyc(ARMC + 4);
    endtask

    task automatic send_bit(input logic b);
        tone_in = 1'b1;
        cyc(b ? BITC / 3 : 2 * BITC / 3);
        tone_in = 1'b0;
        cyc(b ? 2 * BITC / 3 : BITC / 3);
    endtask

    task automatic send_word(input logic [7:0] d, input logic bad);
        logic p;
        p = ~(^d) ^ bad;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        send_bit(p);
    endtask

    task automatic end_msg();
        cyc(3 * BITC);
    endtask

    task automatic rd_status(output logic [7:0] v);
        rd_en = 1'b1; rd_addr = 1'b0;
        cyc(1);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic rd_word(output logic [7:0] v);
        rd_en = 1'b1; rd_addr = 1'b1;
        cyc(1);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic expect_word(input string req, input logic [7:0] d, input logic bad);
        logic [7:0] v;
        logic       p;
        p = ~(^d) ^ bad;
        rd_word(v);
        check(req, {24'b0, v}, {24'b0, d});
        rd_word(v);
        check(req, {24'b0, v}, {24'b0, 6'b0, bad, p});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // Reset state
        check("R10 reset irq", {31'b0, irq}, 0);
        rd_status(v);
        check("R7 reset status", {24'b0, v}, 0);

        // R5: no reply
        irq_en = 1'b1;
        arm();
        cyc(TMO + 20);
        check("R10 irq on no-reply", {31'b0, irq}, 1);
        rd_status(v);
        check("R5 no-reply status", {24'b0, v}, 32'h08);
        check("R10 irq cleared by status read", {31'b0, irq}, 0);

        // R2 R3 R6 R7 R8: all 256 byte values, eight per message
        for (int m = 0; m < 32; m++) begin
            arm();
            for (int i = 0; i < 8; i++) begin
                d = 8'(m * 8 + i);
                send_word(d, (d % 7) == 3);
            end
            end_msg();
            rd_status(v);
            check("R6 R7 full message status", {24'b0, v}, 32'h83);
            for (int i = 0; i < 8; i++) begin
                d = 8'(m * 8 + i);
                expect_word("R2 R3 R8 word", d, (d % 7) == 3);
                rd_status(v);
                check("R7 count after read", {28'b0, v[7:4]}, 32'(7 - i));
            end
        end

        // R4: message lengths 1..7
        for (int len = 1; len < 8; len++) begin
            arm();
            for (int i = 0; i < len; i++) send_word(8'(len * 29 + i), 1'b0);
            end_msg();
            rd_status(v);
            check("R4 complete status", {24'b0, v}, {24'b0, 4'(len), 4'b0011});
            for (int i = 0; i < len; i++) expect_word("R4 word", 8'(len * 29 + i), 1'b0);
        end

        // R9: overflow
        arm();
        for (int i = 0; i < DEP + 2; i++) send_word(8'(8'h40 + i), 1'b0);
        end_msg();
        rd_status(v);
        check("R9 overflow status", {24'b0, v}, 32'h87);
        rd_status(v);
        check("R9 overflow cleared", {24'b0, v}, 32'h83);
        for (int i = 0; i < DEP; i++) expect_word("R9 held word", 8'(8'h40 + i), 1'b0);

        // R4: partial word discarded
        arm();
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        end_msg();
        rd_status(v);
        check("R4 partial discarded", {24'b0, v}, 32'h02);

        // R1: flags cleared on arm, tone during delay ignored
        tx_done = 1'b1;
        cyc(1);
        tx_done = 1'b0;
        rd_status(v);
        check("R1 flags cleared", {24'b0, v}, 0);
        for (int k = 0; k < 2; k++) begin
            tone_in = 1'b1; cyc(8);
            tone_in = 1'b0; cyc(8);
        end
        cyc(ARMC + 4 - 33);
        send_word(8'h3C, 1'b0);
        end_msg();
        rd_status(v);
        check("R1 only real word", {24'b0, v}, 32'h13);
        expect_word("R1 word", 8'h3C, 1'b0);

        // R10: mask
        irq_en = 1'b0;
        arm();
        send_word(8'hC3, 1'b1);
        end_msg();
        check("R10 masked irq", {31'b0, irq}, 0);
        irq_en = 1'b1;
        cyc(1);
        check("R10 unmasked irq", {31'b0, irq}, 1);
        rd_status(v);
        check("R10 irq after read", {31'b0, irq}, 0);
        expect_word("R10 word", 8'hC3, 1'b1);

        // R8: empty read keeps phase
        rd_word(v);
        check("R8 empty read", {24'b0, v}, 0);
        arm();
        send_word(8'hA5, 1'b0);
        end_msg();
        rd_word(v);
        check("R8 first access data", {24'b0, v}, 32'hA5);
        rd_word(v);
        check("R8 second access parity", {24'b0, v}, 32'h01);
        rd_status(v);
        check("R7 empty after pop", {28'b0, v[7:4]}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule